// File: doc/BRIEF.md
# Two-Wire Control Register Target with Block Transfers

This block is a serial target on a two-wire bus (clock and open-drain data) that holds six 8-bit control registers for a clock generator. A controller reaches it at 7-bit address 0x6B and can write or read one register at a time, or move a run of registers in one transfer. Block transfers carry a byte count: the controller sends one after the command code on writes, and the target returns one before the data on reads. Selected register bits drive the block's enable and amplitude outputs directly.

Both bus lines are sampled by the system clock through two-flop synchronizers. Start and stop conditions are recognised from data-line edges while the clock line is high, and every bit is taken or launched on the synchronized clock edges. The data line is never driven high: `sda_oe` asks the pad to pull it low. The code in bit 7 of the command byte picks between byte and block access, and its lower seven bits give the first register index.

Top module: `smb_ctl_regs`

## Requirements
- R1: After reset the registers hold index0=0x04, index1=0x00, index2=0xC0, index3=0x08, index4=0x06, index5=0xD8. `ref_en` is index0 bit 2, `diff0_en` is index2 bit 7, `diff1_en` is index2 bit 6, `amp_sel` is index5 bit 7, and `amp_code` is index5 bits 6:4.
- R2: The target acknowledges an address byte whose upper seven bits are 0x6B (0xD6 for write, 0xD7 for read). It does this by pulling SDA low during the ninth clock.
- R3: In a command byte, bit 7 = 1 selects byte access and bit 7 = 0 selects block access. Bits 6:0 give the starting register index. The index and the access type are kept across a repeated start.
- R4: In a byte write, the single data byte after the command is stored at the index and acknowledged. Any further data byte in the same transfer is not acknowledged and is not stored.
- R5: In a byte read (command, repeated start, 0xD7), the target returns the register at the index, MSB first.
- R6: In a block write, the byte after the command is a count N. The next N bytes are stored at ascending indices starting at the index, and each is acknowledged. Bytes beyond N are not acknowledged and are not stored.
- R7: A block read first returns the current value of index4 as the count. It then returns registers at ascending indices starting at the index.
- R8: During a read, a controller acknowledge makes the target send the next byte. A not-acknowledge makes it release SDA until the next start or stop.
- R9: On an address mismatch the target gives no acknowledge and leaves SDA released for the rest of the transfer. No register changes.
- R10: Indices 6 and above are not implemented. Writes to them are acknowledged and discarded, and reads of them return 0x00.
- R11: The target changes SDA only while SCL is low.
- R12: A stop that arrives before a byte is complete discards that partial byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low |
| ref_en | output | 1 | Reference output enable (index0 bit 2) |
| diff0_en | output | 1 | First differential output enable (index2 bit 7) |
| diff1_en | output | 1 | Second differential output enable (index2 bit 6) |
| amp_sel | output | 1 | Custom amplitude select (index5 bit 7) |
| amp_code | output | 3 | Amplitude code (index5 bits 6:4) |

## Verification
Two events share one synchronized SCL falling edge: the store of the final data byte into a register, and the start of the acknowledge drive on SDA. The bench ends block and byte writes right after that acknowledge, so a wrongly timed store or release would show up as a missing acknowledge or a wrong enable output. A second overlap is between the launch of the next read byte and the sampling of the controller's acknowledge. The bench reads runs of three and four bytes and ends each with a not-acknowledge. A scoreboard compares every returned byte, and the bench then checks that the line is released.

// File: rtl/smb_ctl_regs.sv
module smb_ctl_regs #(
  parameter logic [6:0] DEV_ADDR = 7'h6B,
  parameter int NREG = 6,
  parameter int CNT_REG = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic       ref_en,
  output logic       diff0_en,
  output logic       diff1_en,
  output logic       amp_sel,
  output logic [2:0] amp_code
);
  localparam logic [2:0] S_IDLE = 3'd0, S_RX = 3'd1, S_RACK = 3'd2,
                         S_TX = 3'd3, S_TACK = 3'd4, S_WAIT = 3'd5;
  localparam logic [1:0] B_ADDR = 2'd0, B_CMD = 2'd1, B_CNT = 2'd2, B_DATA = 2'd3;

  function automatic logic [7:0] rst_val(input int i);
    case (i)
      0: rst_val = 8'h04;
      2: rst_val = 8'hC0;
      3: rst_val = 8'h08;
      4: rst_val = 8'h06;
      5: rst_val = 8'hD8;
      default: rst_val = 8'h00;
    endcase
  endfunction

  logic scl_m, scl_s, scl_d, sda_m, sda_s, sda_d;
  logic scl_rise, scl_fall, start_det, stop_det;
  logic [2:0] st;
  logic [1:0] role;
  logic [3:0] bcnt;
  logic [7:0] sh, tx, left, nb;
  logic [6:0] idx;
  logic       bytemode, rd_go, cnt_pend, mack;
  logic [7:0] regs [NREG];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {scl_m, scl_s, scl_d, sda_m, sda_s, sda_d} <= 6'h3F;
    else {scl_m, scl_s, scl_d, sda_m, sda_s, sda_d} <= {scl_i, scl_m, scl_s, sda_i, sda_m, sda_s};

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

  assign nb = cnt_pend ? regs[CNT_REG] : ((int'(idx) < NREG) ? regs[idx] : 8'h00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; role <= B_ADDR; bcnt <= '0; sh <= '0; tx <= '0; left <= '0;
      idx <= '0; bytemode <= 1'b0; rd_go <= 1'b0; cnt_pend <= 1'b0; mack <= 1'b0;
      sda_oe <= 1'b0;
      for (int i = 0; i < NREG; i++) regs[i] <= rst_val(i);
    end else if (start_det) begin
      st <= S_RX; role <= B_ADDR; bcnt <= '0; sda_oe <= 1'b0;
    end else if (stop_det) begin
      st <= S_IDLE; sda_oe <= 1'b0;
    end else begin
      case (st)
        S_RX:
          if (scl_rise && bcnt != 4'd8) begin
            sh <= {sh[6:0], sda_s};
            bcnt <= bcnt + 4'd1;
          end else if (scl_fall && bcnt == 4'd8) begin
            bcnt <= '0;
            case (role)
              B_ADDR:
                if (sh[7:1] == DEV_ADDR) begin
                  rd_go <= sh[0]; cnt_pend <= sh[0] & ~bytemode;
                  role <= B_CMD; sda_oe <= 1'b1; st <= S_RACK;
                end else st <= S_WAIT;
              B_CMD: begin
                idx <= sh[6:0]; bytemode <= sh[7]; left <= 8'd1;
                role <= sh[7] ? B_DATA : B_CNT; sda_oe <= 1'b1; st <= S_RACK;
              end
              B_CNT: begin
                left <= sh; role <= B_DATA; sda_oe <= 1'b1; st <= S_RACK;
              end
              default:
                if (left != 8'd0) begin
                  if (int'(idx) < NREG) regs[idx] <= sh;
                  idx <= idx + 7'd1; left <= left - 8'd1;
                  sda_oe <= 1'b1; st <= S_RACK;
                end else st <= S_WAIT;
            endcase
          end
        S_RACK:
          if (scl_fall) begin
            if (rd_go) begin
              tx <= nb; sda_oe <= ~nb[7]; bcnt <= '0; st <= S_TX;
              if (cnt_pend) cnt_pend <= 1'b0; else idx <= idx + 7'd1;
            end else begin
              sda_oe <= 1'b0; st <= S_RX;
            end
          end
        S_TX:
          if (scl_fall) begin
            if (bcnt == 4'd7) begin
              sda_oe <= 1'b0; mack <= 1'b0; st <= S_TACK;
            end else begin
              bcnt <= bcnt + 4'd1; tx <= {tx[6:0], 1'b0}; sda_oe <= ~tx[6];
            end
          end
        S_TACK:
          if (scl_rise) begin
            if (sda_s) st <= S_WAIT; else mack <= 1'b1;
          end else if (scl_fall && mack) begin
            tx <= nb; sda_oe <= ~nb[7]; bcnt <= '0; st <= S_TX;
            if (cnt_pend) cnt_pend <= 1'b0; else idx <= idx + 7'd1;
          end
        default: ;
      endcase
    end
  end

  assign ref_en   = regs[0][2];
  assign diff0_en = regs[2][7];
  assign diff1_en = regs[2][6];
  assign amp_sel  = regs[5][7];
  assign amp_code = regs[5][6:4];
endmodule

module smb_ctl_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       scl_fall,
  input logic       sda_oe,
  input logic [2:0] st,
  input logic       ref_en,
  input logic       diff0_en,
  input logic       diff1_en,
  input logic       amp_sel,
  input logic [2:0] amp_code
);
  assert_reset_vals_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (ref_en && diff0_en && diff1_en && amp_sel && amp_code == 3'b101));

  assert_drive_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (st == 3'd2 || st == 3'd3));

  assert_regs_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !scl_fall |=> $stable({ref_en, diff0_en, diff1_en, amp_sel, amp_code}));

  assert_quiet_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd5) |-> !sda_oe);

  assert_scl_high_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe));
endmodule

bind smb_ctl_regs smb_ctl_regs_chk u_chk (.*);

// File: tb/smb_ctl_regs_tb.sv
`timescale 1ns/1ps
module smb_ctl_regs_tb;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 10 * CLK_PERIOD;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, tb_low = 1'b0;
  logic sda_oe, ref_en, diff0_en, diff1_en, amp_sel;
  logic [2:0] amp_code;
  wire sda_line = ~(tb_low | sda_oe);

  int checks = 0, errors = 0, glitches = 0;
  logic [7:0] exp_val[$];
  string      exp_tag[$];
  logic [7:0] obs_val;
  event       obs_ev;

  smb_ctl_regs u_dut (.clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .ref_en(ref_en), .diff0_en(diff0_en), .diff1_en(diff1_en),
    .amp_sel(amp_sel), .amp_code(amp_code));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial forever begin
    @(obs_ev);
    if (exp_val.size() == 0) chk("R5 unexpected byte", {24'd0, obs_val}, 32'hFFFF);
    else chk(exp_tag.pop_front(), {24'd0, obs_val}, {24'd0, exp_val.pop_front()});
  end

  task automatic put_bit(input logic b);
    tb_low = ~b; #(Q); scl = 1'b1; #(2*Q); scl = 1'b0; #(Q);
  endtask

  task automatic get_bit(output logic b);
    logic s1;
    tb_low = 1'b0; #(Q); scl = 1'b1; #(5);
    s1 = sda_line; #(2*Q-10); b = sda_line;
    if (s1 !== b) glitches++;
    #(5); scl = 1'b0; #(Q);
  endtask

  task automatic bus_start;
    tb_low = 1'b0; #(Q); scl = 1'b1; #(Q); tb_low = 1'b1; #(Q); scl = 1'b0; #(Q);
  endtask

  task automatic bus_stop;
    tb_low = 1'b1; #(Q); scl = 1'b1; #(Q); tb_low = 1'b0; #(2*Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, input logic exp_ack, input string tag);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_bit(a);
    chk(tag, {31'd0, a}, {31'd0, ~exp_ack});
  endtask

  task automatic rd_byte(input logic give_ack, input logic [7:0] e, input string tag);
    logic bt;
    exp_val.push_back(e); exp_tag.push_back(tag);
    for (int i = 7; i >= 0; i--) begin get_bit(bt); obs_val[i] = bt; end
    ->obs_ev;
    put_bit(~give_ack);
  endtask

  task automatic byte_write(input logic [7:0] cmd, input logic [7:0] d, input string tag);
    bus_start; wr_byte(8'hD6, 1'b1, "R2 addr ack");
    wr_byte(cmd, 1'b1, "R3 cmd ack"); wr_byte(d, 1'b1, tag); bus_stop;
  endtask

  task automatic byte_read(input logic [7:0] cmd, input logic [7:0] e, input string tag);
    bus_start; wr_byte(8'hD6, 1'b1, "R2 addr ack"); wr_byte(cmd, 1'b1, "R3 cmd ack");
    bus_start; wr_byte(8'hD7, 1'b1, "R2 read addr ack");
    rd_byte(1'b0, e, tag); bus_stop;
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic b;
    #(CLK_PERIOD*5); rst_n = 1'b1; #(CLK_PERIOD*5);
    // R1 reset state
    chk("R1 reset outputs", {amp_code, amp_sel, diff1_en, diff0_en, ref_en}, {3'b101, 4'b1111});
    // R5 byte read of index3
    byte_read(8'h83, 8'h08, "R5 byte read idx3");
    // R4 byte write, extra byte refused
    bus_start; wr_byte(8'hD6, 1'b1, "R2 addr ack"); wr_byte(8'h80, 1'b1, "R3 cmd ack");
    wr_byte(8'h00, 1'b1, "R4 data ack"); wr_byte(8'h55, 1'b0, "R4 extra byte nack"); bus_stop;
    chk("R4 ref_en cleared", {31'd0, ref_en}, 32'd0);
    byte_read(8'h80, 8'h00, "R4 readback idx0");
    // R6 block write of two bytes plus one excess
    bus_start; wr_byte(8'hD6, 1'b1, "R2 addr ack"); wr_byte(8'h01, 1'b1, "R3 block cmd ack");
    wr_byte(8'h02, 1'b1, "R6 count ack"); wr_byte(8'hAA, 1'b1, "R6 data1 ack");
    wr_byte(8'h3F, 1'b1, "R6 data2 ack"); wr_byte(8'h77, 1'b0, "R6 excess nack"); bus_stop;
    chk("R6 diff enables cleared", {30'd0, diff0_en, diff1_en}, 32'd0);
    byte_read(8'h83, 8'h08, "R6 excess not stored idx3");
    // R7 block read with count first, R8 nack ends read
    bus_start; wr_byte(8'hD6, 1'b1, "R2 addr ack"); wr_byte(8'h00, 1'b1, "R3 block cmd ack");
    bus_start; wr_byte(8'hD7, 1'b1, "R2 read addr ack");
    rd_byte(1'b1, 8'h06, "R7 count byte");
    rd_byte(1'b1, 8'h00, "R7 idx0");
    rd_byte(1'b1, 8'hAA, "R7 idx1");
    rd_byte(1'b0, 8'h3F, "R7 idx2");
    get_bit(b);
    chk("R8 released after nack", {31'd0, b}, 32'd1);
    bus_stop;
    // R9 address mismatch
    bus_start; wr_byte(8'hD4, 1'b0, "R9 mismatch nack");
    wr_byte(8'h80, 1'b0, "R9 cmd ignored"); wr_byte(8'hFF, 1'b0, "R9 data ignored"); bus_stop;
    chk("R9 outputs unchanged", {amp_code, amp_sel, diff1_en, diff0_en, ref_en}, {3'b101, 4'b1000});
    // R1 amplitude field mapping
    byte_write(8'h85, 8'h30, "R1 idx5 data ack");
    chk("R1 amp fields", {28'd0, amp_sel, amp_code}, {28'd0, 4'b0011});
    // R10 unimplemented index
    byte_write(8'h90, 8'h12, "R10 write ack");
    byte_read(8'h90, 8'h00, "R10 read zero");
    // R7 count follows index4
    byte_write(8'h84, 8'h02, "R7 count reg write");
    bus_start; wr_byte(8'hD6, 1'b1, "R2 addr ack"); wr_byte(8'h02, 1'b1, "R3 block cmd ack");
    bus_start; wr_byte(8'hD7, 1'b1, "R2 read addr ack");
    rd_byte(1'b1, 8'h02, "R7 new count");
    rd_byte(1'b1, 8'h3F, "R7 idx2");
    rd_byte(1'b0, 8'h08, "R7 idx3");
    bus_stop;
    // R12 partial byte discarded
    bus_start; wr_byte(8'hD6, 1'b1, "R2 addr ack"); wr_byte(8'h80, 1'b1, "R3 cmd ack");
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    bus_stop;
    chk("R12 partial byte dropped", {31'd0, ref_en}, 32'd0);
    byte_read(8'h80, 8'h00, "R12 readback idx0");
    // R11 line stable while SCL high
    chk("R11 sda stable in SCL high", glitches, 32'd0);
    #(Q*4);
    chk("R5 scoreboard drained", exp_val.size(), 32'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule